// File: doc/BRIEF.md
# SRAM Built-In Self-Test Engine with Signature Compaction

This block exercises an external asynchronous SRAM without routing a processor's bus to the memory. It has two run types. A fill run writes a pseudo-random word stream, produced by a 16-bit pattern shift register, to every address in a programmable range. A check run reads the same range back and folds every word into a 16-bit multiple-input signature register. That register uses feedback taps that differ from those of the pattern generator.

A host programs the seeds, the run type, the last address and the pass count, then pulses start. The engine repeats the address sweep the requested number of times. It loads the seeds only at the start of a run. After each sweep it presents the current pattern or signature value together with a one-cycle pass strobe. The block makes no pass/fail decision itself. The host compares the reported values against values it computed itself.

Memory accesses come from a small cycle sequencer. It uses the same strobe timing as the functional path: three cycles per write and two per read.

Top module: `sram_bist`

## Requirements
- R1: After reset, busy and pass_done are 0, sram_ce_n, sram_we_n and sram_oe_n are 1, and sram_dq_oe is 0.
- R2: In a fill run (cfg_mode = 0), the word written to each address is the current pattern value. The pattern then advances once per word: shift right by one, and XOR with 0xB400 when the bit shifted out (bit 0) was 1.
- R3: In a check run (cfg_mode = 1), each word read is folded into the signature. The new signature is the old one shifted right by one, XOR 0xD008 when the old bit 0 was 1, then XOR the read word.
- R4: Each pass visits addresses 0 to cfg_last_addr in ascending order, one access per address, and touches no higher address. A run makes cfg_passes passes, and a value of 0 gives one pass.
- R5: The pattern is loaded from cfg_pat_seed and the signature from cfg_sig_seed only when a run starts. Later passes continue from the values reached at the end of the previous pass.
- R6: At the end of each pass, pass_done is high for exactly one cycle. In that cycle pass_sig holds the pattern (fill run) or signature (check run) value after the pass's last word. pass_sig keeps that value until the next pass ends.
- R7: A write access lasts three cycles: address setup, then sram_we_n low for one cycle, then hold. A read access lasts two cycles, with sram_oe_n low and data captured in the second. A run keeps busy high for exactly 3·N·P (fill) or 2·N·P (check) cycles, where N = cfg_last_addr+1 and P is the effective pass count.
- R8: sram_dq_oe is high only during write accesses. It is never high while sram_oe_n is low, and it is low in the cycle before sram_oe_n falls.
- R9: busy rises on the clock edge after start is seen while idle. It falls on the edge that ends the final pass. A start pulse while busy, including in the last busy cycle, is ignored. The configuration inputs are sampled only when a run is launched. The SRAM strobes are inactive whenever busy is 0.
- R10: A cfg_pat_seed of 0x0000 is replaced by 0x0001, so the first word of that fill run is 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, taken only while idle |
| cfg_mode | input | 1 | 0 = fill run, 1 = check run |
| cfg_passes | input | PW | Number of sweeps (0 acts as 1) |
| cfg_last_addr | input | AW | Highest address of each sweep |
| cfg_pat_seed | input | 16 | Pattern register seed |
| cfg_sig_seed | input | 16 | Signature register seed |
| busy | output | 1 | Run in progress |
| pass_done | output | 1 | One-cycle strobe at end of each sweep |
| pass_sig | output | 16 | Pattern or signature value captured at sweep end |
| sram_addr | output | AW | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | 16 | Write data |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_in | input | 16 | Read data from the memory |

## Verification
Two events can land in the same cycle: the start request and the final access of the last pass, which ends the run. The bench raises start in the last busy cycle, after raising it once mid-run with the configuration inputs already changed. It then checks that busy falls on schedule and stays low, that only one pass strobe appears, and that the memory holds the stream of the original seed. Within a run, the end of one pass and the first access of the next sweep share a clock edge. Multi-pass runs judge this by comparing each reported value with a stream the bench computes itself from the seed and the tap constants.

// File: rtl/sram_bist_pkg.sv
package sram_bist_pkg;

    localparam int DW = 16;

    // Feedback constants for right-shifting Galois registers
    localparam logic [DW-1:0] PAT_TAPS = 16'hB400; // x^16+x^14+x^13+x^11+1
    localparam logic [DW-1:0] SIG_TAPS = 16'hD008; // x^16+x^15+x^13+x^4+1

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_W_SETUP,
        ACC_W_STROBE,
        ACC_W_HOLD,
        ACC_R_SETUP,
        ACC_R_SAMPLE
    } acc_state_e;

    function automatic logic [DW-1:0] safe_seed(input logic [DW-1:0] s);
        return (s == '0) ? {{(DW-1){1'b0}}, 1'b1} : s;
    endfunction

endpackage

// File: rtl/bist_shreg.sv
module bist_shreg #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic [W-1:0] mix,
    output logic [W-1:0] val_q,
    output logic [W-1:0] val_nxt
);

    logic [W-1:0] val_d;

    always_comb begin
        val_nxt = ({1'b0, val_q[W-1:1]} ^ (val_q[0] ? TAPS : '0)) ^ mix;
        val_d   = val_q;
        if (load) begin
            val_d = load_val;
        end else if (step) begin
            val_d = val_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

endmodule

// File: rtl/bist_seq.sv
module bist_seq
    import sram_bist_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  logic       rd_mode,
    input  logic       more,
    output logic       word_end,
    output logic       ce_n,
    output logic       we_n,
    output logic       oe_n,
    output logic       dq_oe
);

    acc_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ACC_IDLE:     if (launch) st_d = rd_mode ? ACC_R_SETUP : ACC_W_SETUP;
            ACC_W_SETUP:  st_d = ACC_W_STROBE;
            ACC_W_STROBE: st_d = ACC_W_HOLD;
            ACC_W_HOLD:   st_d = more ? ACC_W_SETUP : ACC_IDLE;
            ACC_R_SETUP:  st_d = ACC_R_SAMPLE;
            ACC_R_SAMPLE: st_d = more ? ACC_R_SETUP : ACC_IDLE;
            default:      st_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ACC_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        word_end = (st_q == ACC_W_HOLD) || (st_q == ACC_R_SAMPLE);
        ce_n     = (st_q == ACC_IDLE);
        we_n     = (st_q != ACC_W_STROBE);
        oe_n     = (st_q != ACC_R_SAMPLE);
        dq_oe    = (st_q == ACC_W_SETUP) || (st_q == ACC_W_STROBE) ||
                   (st_q == ACC_W_HOLD);
    end

endmodule

// File: rtl/sram_bist.sv
module sram_bist
    import sram_bist_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cfg_mode,
    input  logic [PW-1:0] cfg_passes,
    input  logic [AW-1:0] cfg_last_addr,
    input  logic [DW-1:0] cfg_pat_seed,
    input  logic [DW-1:0] cfg_sig_seed,
    output logic          busy,
    output logic          pass_done,
    output logic [DW-1:0] pass_sig,
    output logic [AW-1:0] sram_addr,
    output logic          sram_ce_n,
    output logic          sram_we_n,
    output logic          sram_oe_n,
    output logic [DW-1:0] sram_dq_out,
    output logic          sram_dq_oe,
    input  logic [DW-1:0] sram_dq_in
);

    typedef struct packed {
        logic          busy;
        logic          rd;
        logic [AW-1:0] addr;
        logic [AW-1:0] last;
        logic [PW-1:0] pass_cnt;
        logic [PW-1:0] pass_max;
        logic          done;
        logic [DW-1:0] sig;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          launch, more, word_end;
    logic [DW-1:0] pat_q, pat_nxt, sig_q, sig_nxt;

    always_comb begin
        launch = start && !ctl_q.busy;
        more   = !((ctl_q.addr == ctl_q.last) && (ctl_q.pass_cnt == ctl_q.pass_max));

        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (launch) begin
            ctl_d.busy     = 1'b1;
            ctl_d.rd       = cfg_mode;
            ctl_d.addr     = '0;
            ctl_d.last     = cfg_last_addr;
            ctl_d.pass_cnt = '0;
            ctl_d.pass_max = (cfg_passes == '0) ? '0 : cfg_passes - PW'(1);
        end else if (word_end) begin
            if (ctl_q.addr == ctl_q.last) begin
                ctl_d.addr = '0;
                ctl_d.done = 1'b1;
                ctl_d.sig  = ctl_q.rd ? sig_nxt : pat_nxt;
                if (ctl_q.pass_cnt == ctl_q.pass_max) begin
                    ctl_d.busy = 1'b0;
                end else begin
                    ctl_d.pass_cnt = ctl_q.pass_cnt + PW'(1);
                end
            end else begin
                ctl_d.addr = ctl_q.addr + AW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    bist_shreg #(.W(DW), .TAPS(PAT_TAPS)) u_pat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .load_val (safe_seed(cfg_pat_seed)),
        .step     (word_end && !ctl_q.rd),
        .mix      ('0),
        .val_q    (pat_q),
        .val_nxt  (pat_nxt)
    );

    bist_shreg #(.W(DW), .TAPS(SIG_TAPS)) u_sig (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .load_val (cfg_sig_seed),
        .step     (word_end && ctl_q.rd),
        .mix      (sram_dq_in),
        .val_q    (sig_q),
        .val_nxt  (sig_nxt)
    );

    bist_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .rd_mode  (cfg_mode),
        .more     (more),
        .word_end (word_end),
        .ce_n     (sram_ce_n),
        .we_n     (sram_we_n),
        .oe_n     (sram_oe_n),
        .dq_oe    (sram_dq_oe)
    );

    logic unused_sig;
    assign unused_sig = ^sig_q;

    assign busy        = ctl_q.busy;
    assign pass_done   = ctl_q.done;
    assign pass_sig    = ctl_q.sig;
    assign sram_addr   = ctl_q.addr;
    assign sram_dq_out = pat_q;

endmodule

// File: rtl/sram_bist_chk.sv
module sram_bist_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          pass_done,
    input logic [AW-1:0] sram_addr,
    input logic          sram_ce_n,
    input logic          sram_we_n,
    input logic          sram_oe_n,
    input logic          sram_dq_oe
);

    // R8
    bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_oe_n) |-> !sram_dq_oe && !$past(sram_dq_oe));

    // R8
    no_drive_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> !sram_dq_oe);

    // R7
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |=> sram_we_n);

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> $stable(sram_addr) && sram_dq_oe);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe);

    // R9
    busy_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done);

    // R6
    done_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> $past(busy));

endmodule

bind sram_bist sram_bist_chk #(.AW(AW)) u_chk (.*);

// File: tb/sram_bist_tb.sv
module sram_bist_tb;

    localparam int AW = 4;
    localparam int PW = 3;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic          cfg_mode;
    logic [PW-1:0] cfg_passes;
    logic [AW-1:0] cfg_last_addr;
    logic [DW-1:0] cfg_pat_seed, cfg_sig_seed;
    logic          busy, pass_done;
    logic [DW-1:0] pass_sig;
    logic [AW-1:0] sram_addr;
    logic          sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [DW-1:0] sram_dq_out, sram_dq_in;

    always #5 clk = ~clk;

    sram_bist #(.AW(AW), .PW(PW)) u_dut (.*);

    logic [DW-1:0] mem [16];
    logic [DW-1:0] plog [8];
    int pn;
    int bus_viol = 0;
    logic prev_dq_oe = 1'b0;
    int errs = 0;
    int checks = 0;

    assign sram_dq_in = !sram_oe_n ? mem[sram_addr] : 16'h0000;

    always @(posedge clk) begin
        if (!sram_ce_n && !sram_we_n) mem[sram_addr] <= sram_dq_out;
    end

    always @(negedge clk) begin
        if (pass_done) begin
            if (pn < 8) plog[pn] = pass_sig;
            pn++;
        end
        if (rst_n) begin
            if (!sram_oe_n && sram_dq_oe) bus_viol++;
            if (!sram_we_n && !sram_dq_oe) bus_viol++;
            if (!sram_oe_n && prev_dq_oe) bus_viol++;
        end
        prev_dq_oe = sram_dq_oe;
    end

    function automatic logic [15:0] pat_step(input logic [15:0] s);
        return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
    endfunction

    function automatic logic [15:0] sig_step(input logic [15:0] s, input logic [15:0] d);
        return ((s >> 1) ^ (s[0] ? 16'hD008 : 16'h0000)) ^ d;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic m, input logic [PW-1:0] p, input logic [AW-1:0] l,
                       input logic [15:0] ps, input logic [15:0] ss, output int cyc);
        @(negedge clk);
        cfg_mode = m; cfg_passes = p; cfg_last_addr = l;
        cfg_pat_seed = ps; cfg_sig_seed = ss;
        start = 1'b1; pn = 0;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        int cyc;
        logic [15:0] s;
        logic [15:0] keep4;
        rst_n = 1'b0; start = 1'b0; cfg_mode = 1'b0; cfg_passes = '0;
        cfg_last_addr = '0; cfg_pat_seed = '0; cfg_sig_seed = '0; pn = 0;
        for (int i = 0; i < 16; i++) mem[i] = 16'hDEAD;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !pass_done, "R1", "busy/pass_done", {busy, pass_done}, 0);
        check(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R1", "strobes",
              {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b1110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Fill run: 2 passes over addresses 0..5
        run(1'b0, 3'd2, 4'd5, 16'hACE1, 16'h0000, cyc);
        check(cyc == 36, "R7", "fill busy cycles", cyc, 36);
        check(pn == 2, "R4", "fill pass count", pn, 2);
        s = 16'hACE1;
        for (int p = 0; p < 2; p++) begin
            for (int a = 0; a < 6; a++) begin
                if (p == 1) check(mem[a] == s, "R2", "fill word", mem[a], s);
                s = pat_step(s);
            end
            // R5 stream continues across passes, R6 value after last word
            check(plog[p] == s, "R6", "fill pass value", plog[p], s);
        end
        for (int a = 6; a < 16; a++)
            check(mem[a] == 16'hDEAD, "R4", "address above last untouched", mem[a], 16'hDEAD);

        // Check run: 3 passes over 0..5
        run(1'b1, 3'd3, 4'd5, 16'h0000, 16'h1234, cyc);
        check(cyc == 36, "R7", "check busy cycles", cyc, 36);
        check(pn == 3, "R4", "check pass count", pn, 3);
        s = 16'h1234;
        for (int p = 0; p < 3; p++) begin
            for (int a = 0; a < 6; a++) s = sig_step(s, mem[a]);
            check(plog[p] == s, "R3", "signature per pass (R5)", plog[p], s);
        end

        // R10 zero seed, full range
        run(1'b0, 3'd1, 4'd15, 16'h0000, 16'h0000, cyc);
        check(mem[0] == 16'h0001, "R10", "first word of zero seed", mem[0], 16'h0001);
        check(cyc == 48, "R7", "full-range busy cycles", cyc, 48);
        s = 16'h0001;
        for (int a = 0; a < 16; a++) begin
            check(mem[a] == s, "R2", "zero-seed stream", mem[a], s);
            s = pat_step(s);
        end
        keep4 = mem[4];

        // R4 pass count 0 acts as one pass, single address
        run(1'b1, 3'd0, 4'd0, 16'h0000, 16'h0F0F, cyc);
        check(cyc == 2, "R4", "zero passes busy cycles", cyc, 2);
        check(pn == 1, "R4", "zero passes strobes", pn, 1);
        check(plog[0] == sig_step(16'h0F0F, mem[0]), "R3", "single-word signature",
              plog[0], sig_step(16'h0F0F, mem[0]));

        // R9 start while busy: mid-run and in the final busy cycle
        @(negedge clk);
        cfg_mode = 1'b0; cfg_passes = 3'd1; cfg_last_addr = 4'd3;
        cfg_pat_seed = 16'h5A5A; cfg_sig_seed = 16'h0000;
        start = 1'b1; pn = 0;
        @(negedge clk);
        start = 1'b0;
        cfg_mode = 1'b1; cfg_passes = 3'd7; cfg_last_addr = 4'd15; cfg_pat_seed = 16'h0000;
        cyc = 0;
        while (busy && cyc < 5000) begin
            cyc++;
            start = (cyc == 6) || (cyc == 12);
            @(negedge clk);
        end
        start = 1'b0;
        check(cyc == 12, "R9", "run length with ignored starts", cyc, 12);
        for (int k = 0; k < 3; k++) begin
            check(!busy && sram_ce_n, "R9", "stays idle after final-cycle start",
                  {busy, sram_ce_n}, 2'b01);
            @(negedge clk);
        end
        check(pn == 1, "R9", "single strobe", pn, 1);
        s = 16'h5A5A;
        for (int a = 0; a < 4; a++) begin
            check(mem[a] == s, "R9", "config latched at launch", mem[a], s);
            s = pat_step(s);
        end
        check(plog[0] == s, "R6", "value after last word", plog[0], s);
        check(mem[4] == keep4, "R4", "address past last kept", mem[4], keep4);

        // R8 bus ownership over all runs
        check(bus_viol == 0, "R8", "bus drive violations", bus_viol, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule